// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This block carries out the eight integer multiply, divide and remainder operations of a 32-bit RISC-style core. A 3-bit operation code, two operands and a one-cycle start strobe go in. The block hands back one result word together with a one-cycle completion strobe. The operand width is the parameter `XLEN`, which defaults to 32. Multiplication finishes after one registered cycle. Division and remainder go through an iterative restoring divider that produces one quotient bit per clock. Signed division is done on operand magnitudes, and the signs are applied afterwards. A divisor of zero and the single signed-overflow pair are recognised when the operation is accepted, and they complete without entering the divider.

The control is a four-state machine. The states are:
- `ST_IDLE`: waiting for a start.
- `ST_MUL`: the registered operands pass through the multiplier.
- `ST_DIV`: one divider step per cycle.
- `ST_FIX`: the signs are applied and the result is written.

The transitions are:
- IDLE→MUL on an accepted multiply.
- IDLE→DIV on an accepted divide or remainder that is not a special case.
- IDLE→IDLE on an accepted special case, which completes directly.
- MUL→IDLE after one cycle.
- DIV→FIX on the final divider step.
- FIX→IDLE after one cycle.

A start is accepted only in `ST_IDLE`.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 0 returns the low XLEN bits of the product of the two operands.
- R2: Operation codes 1, 2 and 3 return the high XLEN bits of the 2·XLEN-bit product. Code 1 treats both operands as signed. Code 2 treats `src_a` as signed and `src_b` as unsigned. Code 3 treats both as unsigned.
- R3: Codes 4 (signed) and 5 (unsigned) return the quotient, and codes 6 (signed) and 7 (unsigned) return the remainder. The signed quotient is truncated toward zero, and the signed remainder carries the sign of the dividend.
- R4: Codes 4 and 5 with a zero divisor return all ones.
- R5: Codes 6 and 7 with a zero divisor return the dividend unchanged.
- R6: A signed divide of the most negative value by minus one returns the most negative value under code 4 and zero under code 6.
- R7: A special case from R4 to R6 raises `done` in the cycle after the start cycle, and `busy` never rises for it.
- R8: A multiply raises `done` two cycles after the start cycle, with `busy` high for exactly the one cycle between.
- R9: A non-special divide or remainder raises `done` XLEN+2 cycles after the start cycle, with `busy` high for the XLEN+1 cycles between.
- R10: `busy` rises only in the cycle after a start, is high from then until the completion cycle, and is never high together with `done`.
- R11: A start asserted while `busy` is high is ignored. The running operation's result and timing are unchanged, and no extra completion follows.
- R12: `done` is a one-cycle pulse. `result` changes only in a cycle where `done` is high and holds its value until the next completion.
- R13: After reset, `done` and `busy` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the present `op`, `src_a` and `src_b` |
| op | input | 3 | Operation code; bit 2 clear selects multiply, set selects divide/remainder |
| src_a | input | XLEN | First operand (multiplicand or dividend) |
| src_b | input | XLEN | Second operand (multiplier or divisor) |
| result | output | XLEN | Result of the most recently completed operation |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | An accepted multiply or divide is in progress |

## Verification
Some properties are checked by assertions on every cycle:
- the completion latency of each operation class, with a counter for the divide window;
- the exclusion of `busy` and `done`, and the pulse shape of `done`;
- the stability of `result` between completions;
- the exact values returned for the zero-divisor and overflow cases;
- the low and unsigned-high product values.

Other behaviours are shown only by the bench's scenarios:
- the full arithmetic of the signed divide;
- the mixed-sign high products;
- a start that arrives while the divider is running and must leave no trace;
- an exhaustive sweep of every operation and operand pair at 4-bit width, checked against a reference computed arithmetically.

// File: rtl/md_pkg.sv
package md_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_MULH   = 3'd1,
        OP_MULHSU = 3'd2,
        OP_MULHU  = 3'd3,
        OP_DIV    = 3'd4,
        OP_DIVU   = 3'd5,
        OP_REM    = 3'd6,
        OP_REMU   = 3'd7
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_FIX
    } md_state_e;

    typedef struct packed {
        logic is_div;
        logic want_rem;
        logic want_hi;
        logic sgn_a;
        logic sgn_b;
    } md_ctrl_t;

endpackage

// File: rtl/md_decode.sv
// Operation decode and early detection of the fixed-result divide cases.
module md_decode
    import md_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output md_ctrl_t        ctrl,
    output logic            special,
    output logic [XLEN-1:0] special_val
);

    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ALL_ONES = '1;

    logic zero_div;
    logic ovf;

    always_comb begin
        ctrl.is_div   = op[2];
        ctrl.want_rem = op[2] & op[1];
        ctrl.want_hi  = ~op[2] & (op[1:0] != 2'b00);
        if (op[2]) begin
            // signed divide group when bit 0 is clear
            ctrl.sgn_a = ~op[0];
            ctrl.sgn_b = ~op[0];
        end else begin
            ctrl.sgn_a = (op[1:0] == 2'b01) | (op[1:0] == 2'b10);
            ctrl.sgn_b = (op[1:0] == 2'b01);
        end
    end

    assign zero_div = op[2] & (opb == '0);
    assign ovf      = op[2] & ~op[0] & (opa == MOST_NEG) & (opb == ALL_ONES);
    assign special  = zero_div | ovf;

    always_comb begin
        if (zero_div) begin
            special_val = ctrl.want_rem ? opa : ALL_ONES;
        end else begin
            special_val = ctrl.want_rem ? '0 : MOST_NEG;
        end
    end

endmodule

// File: rtl/md_mult.sv
// Single-pass multiplier: sign-extend to the double width, keep the low 2*XLEN bits.
module md_mult #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            sgn_a,
    input  logic            sgn_b,
    input  logic            want_hi,
    output logic [XLEN-1:0] prod
);

    localparam int PW = 2 * XLEN;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] full;

    assign ext_a = {{XLEN{sgn_a & opa[XLEN-1]}}, opa};
    assign ext_b = {{XLEN{sgn_b & opb[XLEN-1]}}, opb};
    assign full  = ext_a * ext_b;
    assign prod  = want_hi ? full[PW-1:XLEN] : full[XLEN-1:0];

endmodule

// File: rtl/md_divcore.sv
// Unsigned radix-2 restoring divider, one quotient bit per clock.
module md_divcore #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            last,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);

    localparam int CW = $clog2(XLEN + 1);

    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] dsr_q;
    logic [CW-1:0]   cnt_q;

    logic [XLEN:0]   partial;
    logic            fits;
    logic [XLEN-1:0] sub_lo;
    logic [XLEN-1:0] rem_n;
    logic [XLEN-1:0] quo_n;

    always_comb begin
        partial = {rem_q, quo_q[XLEN-1]};
        fits    = partial >= {1'b0, dsr_q};
        sub_lo  = XLEN'(partial - {1'b0, dsr_q});
        rem_n   = fits ? sub_lo : partial[XLEN-1:0];
        quo_n   = {quo_q[XLEN-2:0], fits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            dsr_q <= divisor;
            cnt_q <= CW'(XLEN);
        end else if (cnt_q != '0) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CW'(1));
    assign quo  = quo_q;
    assign rem  = rem_q;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import md_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] result,
    output logic            done,
    output logic            busy
);

    md_state_e state_q, state_n;

    md_ctrl_t        ctrl;
    logic            special;
    logic [XLEN-1:0] special_val;

    logic            accept;
    logic            neg_a, neg_b;
    logic [XLEN-1:0] mag_a, mag_b;
    logic            div_load;
    logic            div_last;
    logic [XLEN-1:0] div_quo, div_rem;

    logic [XLEN-1:0] a_q, b_q;
    logic            hi_q, sa_q, sb_q, rsel_q;
    logic            qneg_q, rneg_q;
    logic [XLEN-1:0] mul_res;
    logic [XLEN-1:0] result_q;
    logic            done_q;

    md_decode #(.XLEN(XLEN)) u_decode (
        .op          (op),
        .opa         (src_a),
        .opb         (src_b),
        .ctrl        (ctrl),
        .special     (special),
        .special_val (special_val)
    );

    assign accept   = start & (state_q == ST_IDLE);
    assign neg_a    = ctrl.sgn_a & src_a[XLEN-1];
    assign neg_b    = ctrl.sgn_b & src_b[XLEN-1];
    assign mag_a    = neg_a ? (~src_a + 1'b1) : src_a;
    assign mag_b    = neg_b ? (~src_b + 1'b1) : src_b;
    assign div_load = accept & ctrl.is_div & ~special;

    md_divcore #(.XLEN(XLEN)) u_divcore (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (mag_a),
        .divisor  (mag_b),
        .last     (div_last),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    md_mult #(.XLEN(XLEN)) u_mult (
        .opa     (a_q),
        .opb     (b_q),
        .sgn_a   (sa_q),
        .sgn_b   (sb_q),
        .want_hi (hi_q),
        .prod    (mul_res)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next-state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !special) begin
                    state_n = ctrl.is_div ? ST_DIV : ST_MUL;
                end
            end
            ST_MUL:  state_n = ST_IDLE;
            ST_DIV:  if (div_last) state_n = ST_FIX;
            ST_FIX:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs and captured operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            hi_q     <= 1'b0;
            sa_q     <= 1'b0;
            sb_q     <= 1'b0;
            rsel_q   <= 1'b0;
            qneg_q   <= 1'b0;
            rneg_q   <= 1'b0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        a_q    <= src_a;
                        b_q    <= src_b;
                        hi_q   <= ctrl.want_hi;
                        sa_q   <= ctrl.sgn_a;
                        sb_q   <= ctrl.sgn_b;
                        rsel_q <= ctrl.want_rem;
                        qneg_q <= neg_a ^ neg_b;
                        rneg_q <= neg_a;
                        if (special) begin
                            result_q <= special_val;
                            done_q   <= 1'b1;
                        end
                    end
                end
                ST_MUL: begin
                    result_q <= mul_res;
                    done_q   <= 1'b1;
                end
                ST_DIV: begin
                end
                ST_FIX: begin
                    if (rsel_q) begin
                        result_q <= rneg_q ? (~div_rem + 1'b1) : div_rem;
                    end else begin
                        result_q <= qneg_q ? (~div_quo + 1'b1) : div_quo;
                    end
                    done_q <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign result = result_q;
    assign done   = done_q;
    assign busy   = (state_q != ST_IDLE);

endmodule

// File: rtl/md_checker.sv
module md_checker
    import md_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2:0]      op,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [XLEN-1:0] result,
    input logic            done,
    input logic            busy
);

    localparam int PW = 2 * XLEN;
    localparam int RW = $clog2(XLEN + 3);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic          acc;
    logic [PW-1:0] uprod;
    logic [RW-1:0] run_q;
    logic          kdiv_q;

    assign acc   = start & ~busy;
    assign uprod = PW'(src_a) * PW'(src_b);

    // length of the busy run that ended just before the current cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            kdiv_q <= 1'b0;
        end else begin
            run_q <= busy ? run_q + 1'b1 : '0;
            if (acc) kdiv_q <= op[2];
        end
    end

    p_mul_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op == OP_MUL |-> ##2 (done && result == $past(uprod[XLEN-1:0], 2)));

    p_mulhu_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op == OP_MULHU |-> ##2 (done && result == $past(uprod[PW-1:XLEN], 2)));

    p_div_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op[2] && !op[1] && src_b == '0 |=> done && result == '1);

    p_rem_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op[2] && op[1] && src_b == '0 |=> done && result == $past(src_a));

    p_ovf_quo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op == OP_DIV && src_a == MOST_NEG && src_b == '1 |=> done && result == MOST_NEG);

    p_ovf_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op == OP_REM && src_a == MOST_NEG && src_b == '1 |=> done && result == '0);

    p_special_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op[2] && src_b == '0 |=> !busy);

    p_mul_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !op[2] |=> busy ##1 (done && !busy));

    p_div_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && kdiv_q && run_q != '0 |-> run_q == RW'(XLEN + 1));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

endmodule

bind muldiv_unit md_checker #(.XLEN(XLEN)) u_md_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .src_a  (src_a),
    .src_b  (src_b),
    .result (result),
    .done   (done),
    .busy   (busy)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;

    localparam int WB = 32;
    localparam int WS = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;

    logic          b_start;
    logic [2:0]    b_op;
    logic [WB-1:0] b_a, b_b, b_res;
    logic          b_done, b_busy;

    logic          s_start;
    logic [2:0]    s_op;
    logic [WS-1:0] s_a, s_b, s_res;
    logic          s_done, s_busy;

    int n_chk = 0;
    int n_bad = 0;

    muldiv_unit #(.XLEN(WB)) u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(b_start), .op(b_op),
        .src_a(b_a), .src_b(b_b), .result(b_res), .done(b_done), .busy(b_busy)
    );

    muldiv_unit #(.XLEN(WS)) u_muldiv_unit_small (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op(s_op),
        .src_a(s_a), .src_b(s_b), .result(s_res), .done(s_done), .busy(s_busy)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint sx(input int w, input longint v);
        return (((v >> (w - 1)) & 1) != 0) ? v - (longint'(1) << w) : v;
    endfunction

    // reference value from the requirements
    function automatic longint refm(input int w, input int op, input longint a, input longint b);
        longint mask = (longint'(1) << w) - 1;
        longint minv = longint'(1) << (w - 1);
        longint sa = sx(w, a);
        longint sb = sx(w, b);
        longint p;
        case (op)
            0: begin p = a * b;   return p & mask; end
            1: begin p = sa * sb; return (p >> w) & mask; end
            2: begin p = sa * b;  return (p >> w) & mask; end
            3: begin p = a * b;   return (p >> w) & mask; end
            4: begin
                if (b == 0) return mask;
                if (a == minv && b == mask) return minv;
                return (sa / sb) & mask;
            end
            5: begin
                if (b == 0) return mask;
                return a / b;
            end
            6: begin
                if (b == 0) return a;
                if (a == minv && b == mask) return 0;
                return (sa % sb) & mask;
            end
            default: begin
                if (b == 0) return a;
                return a % b;
            end
        endcase
    endfunction

    function automatic bit is_special(input int w, input int op, input longint a, input longint b);
        longint mask = (longint'(1) << w) - 1;
        if (op < 4) return 1'b0;
        if (b == 0) return 1'b1;
        return ((op == 4 || op == 6) && a == (longint'(1) << (w - 1)) && b == mask);
    endfunction

    function automatic string val_tag(input int w, input int op, input longint a, input longint b);
        longint mask = (longint'(1) << w) - 1;
        if (op == 0) return "R1";
        if (op < 4) return "R2";
        if (b == 0) return (op >= 6) ? "R5" : "R4";
        if ((op == 4 || op == 6) && a == (longint'(1) << (w - 1)) && b == mask) return "R6";
        return "R3";
    endfunction

    function automatic int exp_lat(input int w, input int op, input longint a, input longint b);
        if (is_special(w, op, a, b)) return 1;
        if (op < 4) return 2;
        return w + 2;
    endfunction

    function automatic string lat_tag(input int w, input int op, input longint a, input longint b);
        if (is_special(w, op, a, b)) return "R7";
        if (op < 4) return "R8";
        return "R9";
    endfunction

    // called at a falling edge; returns there
    task automatic run_big(input int op, input longint a, input longint b);
        int lat;
        int bcy;
        b_op = 3'(op); b_a = WB'(a); b_b = WB'(b); b_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b_start = 1'b0;
        lat = 1; bcy = 0;
        while (!b_done && lat < 100) begin
            if (b_busy) bcy++;
            @(negedge clk);
            lat++;
        end
        chk(longint'(b_res) == refm(WB, op, a, b), val_tag(WB, op, a, b),
            longint'(b_res), refm(WB, op, a, b));
        chk(lat == exp_lat(WB, op, a, b), lat_tag(WB, op, a, b), lat, exp_lat(WB, op, a, b));
        chk(bcy == lat - 1 && !b_busy, "R10 busy span", bcy, lat - 1);
    endtask

    task automatic run_small(input int op, input longint a, input longint b);
        int lat;
        s_op = 3'(op); s_a = WS'(a); s_b = WS'(b); s_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_start = 1'b0;
        lat = 1;
        while (!s_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(longint'(s_res) == refm(WS, op, a, b), val_tag(WS, op, a, b),
            longint'(s_res), refm(WS, op, a, b));
        chk(lat == exp_lat(WS, op, a, b), lat_tag(WS, op, a, b), lat, exp_lat(WS, op, a, b));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired before completion");
        finish_run();
    end

    initial begin
        int lat;
        logic [WB-1:0] held;
        rst_n = 1'b0;
        b_start = 1'b0; b_op = '0; b_a = '0; b_b = '0;
        s_start = 1'b0; s_op = '0; s_a = '0; s_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk(!b_done && !b_busy && b_res == '0, "R13 big", {b_done, b_busy}, 0);
        chk(!s_done && !s_busy && s_res == '0, "R13 small", {s_done, s_busy}, 0);

        // directed, full width
        run_big(0, 64'h12345678, 64'h9abcdef0);
        run_big(0, 64'hffffffff, 64'h00000003);
        run_big(1, 64'hffffffff, 64'hffffffff);
        run_big(1, 64'h80000000, 64'h80000000);
        run_big(1, 64'h7fffffff, 64'h80000000);
        run_big(2, 64'hffffffff, 64'hffffffff);
        run_big(2, 64'h00000005, 64'hfffffff0);
        run_big(3, 64'hffffffff, 64'hffffffff);
        run_big(4, 64'hfffffff9, 64'h00000002);
        run_big(6, 64'hfffffff9, 64'h00000002);
        run_big(4, 64'h00000007, 64'hfffffffe);
        run_big(6, 64'h00000007, 64'hfffffffe);
        run_big(5, 64'hfffffff9, 64'h00000002);
        run_big(7, 64'hfffffff9, 64'h00000010);
        run_big(4, 64'h80000000, 64'h00000001);
        run_big(4, 64'h12345678, 64'h0);
        run_big(5, 64'h12345678, 64'h0);
        run_big(6, 64'h12345678, 64'h0);
        run_big(7, 64'h87654321, 64'h0);
        run_big(4, 64'h80000000, 64'hffffffff);
        run_big(6, 64'h80000000, 64'hffffffff);
        run_big(5, 64'h80000000, 64'hffffffff);

        // R11: start while a divide runs
        b_op = 3'd4; b_a = 32'd100; b_b = 32'd7; b_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b_start = 1'b0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        b_op = 3'd0; b_a = 32'd5; b_b = 32'd5; b_start = 1'b1;
        @(negedge clk);
        lat++;
        b_start = 1'b0;
        while (!b_done && lat < 100) begin @(negedge clk); lat++; end
        chk(b_res == 32'd14, "R11 result", b_res, 14);
        chk(lat == WB + 2, "R11 latency", lat, WB + 2);
        @(negedge clk);
        chk(!b_done, "R12 done pulse", b_done, 0);
        repeat (3) begin
            @(negedge clk);
            chk(!b_done, "R11 no extra completion", b_done, 0);
        end

        // R12: result holds while inputs move without start
        held = b_res;
        for (int i = 0; i < 4; i++) begin
            b_op = 3'(i); b_a = WB'(i * 977 + 3); b_b = WB'(i + 11);
            @(negedge clk);
            chk(b_res == held && !b_done, "R12 hold", b_res, held);
        end

        // exhaustive sweep of the narrow instance
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < (1 << WS); a++) begin
                for (int b = 0; b < (1 << WS); b++) begin
                    run_small(op, longint'(a), longint'(b));
                end
            end
        end

        finish_run();
    end

endmodule